// File: doc/BRIEF.md
# Two-Phase Memory Repair Sequencer

This block is the control state machine of an on-die memory repair flow. It does not test, analyse or program anything itself. It drives four external engines through single-cycle start strobes and waits for each one's done pulse and pass flag. The engines are a self-test and self-repair engine for the one-time-programmable (OTP) repair store, an SRAM test engine, a redundancy analysis engine and a signature programmer. The first phase qualifies the OTP store. The second phase, which runs only on a clean store, tests the SRAM, allocates spare rows and columns, and writes the resulting signatures into the store.

A mode input, sampled at start, selects where the signatures go. Factory mode writes the factory region, index 0. Field mode appends to the next unused incremental region, so data already programmed is never overwritten. A saturating pointer counts the incremental regions used. Programmed signatures reach the SRAM only through the boot-time loader at the next power-up; the sequencer applies nothing directly.

Every engine wait is guarded by a programmable timeout. The outcome of a run is reported as a 3-bit status code, which stays unchanged until the next start.

Top module: `repair_seq`

## Requirements
- R1: While reset is active and right after its release: status is 0 (idle), busy is 0, all four engine strobes are 0 and the incremental-region count is 0.
- R2: A start pulse while idle sets status to 1 (busy) and raises otp_start for exactly one cycle. A start pulse while busy is ignored: no second OTP launch occurs, and the run completes normally.
- R3: If the OTP engine reports failure, the run ends with status 3 and the SRAM test is never launched.
- R4: After a passing OTP phase, the engines are launched in this order: SRAM test, then analysis (only if the test found failures), then programming (only if analysis succeeded). A successful programming step ends with status 2 (pass).
- R5: An SRAM test that reports no failures ends the run with status 2 without launching analysis or programming.
- R6: If analysis reports the redundancy exhausted (ra_ok=0), the run ends with status 4 and nothing is programmed.
- R7: In factory mode (field_mode=0), pg_region is 0 while pg_start is high, and the incremental-region count is not changed.
- R8: In field mode, pg_region equals the incremental-region count plus one. A successful programming step increments the count by one, so consecutive field repairs target consecutive fresh regions 1..N_INC.
- R9: A field-mode run that reaches programming with all N_INC incremental regions used ends with status 5 and launches no programming. Factory runs are unaffected by a full pointer.
- R10: A wait on an engine is accepted if done arrives at any of the first timeout_lim+1 clock edges after the strobe cycle begins. Otherwise the run ends with status 6, and tmo_phase names the stuck engine (0 OTP, 1 SRAM test, 2 analysis, 3 programming). timeout_lim=0 disables the timeout.
- R11: A programmer failure ends the run with status 7 and leaves the incremental-region count unchanged.
- R12: Once a run has ended, status keeps its value until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to run the flow |
| field_mode | input | 1 | 1 = append to an incremental region, 0 = factory region; sampled at start |
| timeout_lim | input | TW | Cycles allowed per engine wait; 0 disables |
| otp_start | output | 1 | Launch OTP self-test and self-repair |
| otp_done | input | 1 | OTP engine finished |
| otp_pass | input | 1 | OTP store is defect-free after self-repair |
| mt_start | output | 1 | Launch SRAM test |
| mt_done | input | 1 | SRAM test finished |
| mt_pass | input | 1 | SRAM test found no failures |
| ra_start | output | 1 | Launch redundancy analysis |
| ra_done | input | 1 | Analysis finished |
| ra_ok | input | 1 | A repair solution exists |
| pg_start | output | 1 | Launch signature programming |
| pg_region | output | RW | Target region index for programming |
| pg_done | input | 1 | Programmer finished |
| pg_pass | input | 1 | Programming verified |
| busy | output | 1 | A run is in progress |
| status | output | 3 | Run outcome code |
| tmo_phase | output | 2 | Engine that timed out |
| inc_used | output | RW | Incremental regions used so far |

## Verification
The hardest states to reach are the REGION_FULL exit and the exact timeout edge. The first needs N_INC successful field repairs to fill the pointer, and only then a further field run that gets through analysis. The second needs a done pulse that lands on the last accepted edge, and another that lands one edge later. The bench uses engine models with programmable latency, hang and verdict. It fills the pointer with seven consecutive field runs, checking the target region of each. It then sets the response delay to timeout_lim and to timeout_lim+1 to probe both sides of the boundary.

// File: rtl/repair_seq_pkg.sv
package repair_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_BUSY      = 3'd1,
    ST_PASS      = 3'd2,
    ST_FAIL_OTP  = 3'd3,
    ST_UNREP     = 3'd4,
    ST_FULL      = 3'd5,
    ST_TIMEOUT   = 3'd6,
    ST_PROG_FAIL = 3'd7
  } rs_status_e;

  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_OTP  = 3'd1,
    F_MT   = 3'd2,
    F_RA   = 3'd3,
    F_PG   = 3'd4
  } rs_fsm_e;

  localparam int unsigned NUM_ENG = 4;
  localparam int unsigned E_OTP   = 0;
  localparam int unsigned E_MT    = 1;
  localparam int unsigned E_RA    = 2;
  localparam int unsigned E_PG    = 3;

  // Engine index served by a wait state.
  function automatic logic [1:0] phase_of(input rs_fsm_e s);
    case (s)
      F_MT:    return 2'd1;
      F_RA:    return 2'd2;
      F_PG:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // Timeout rule: zero limit disables, else expire once the count reaches the limit.
  function automatic logic wait_expired(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt >= lim);
  endfunction

  // Region a programming step targets: 0 for factory, next fresh slot for field.
  function automatic logic [31:0] next_region(input logic [31:0] used, input logic field);
    return field ? used + 32'd1 : 32'd0;
  endfunction

endpackage

// File: rtl/repair_seq_timer.sv
module repair_seq_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [TW-1:0] lim,
  output logic          expired
);
  import repair_seq_pkg::*;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (run && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && wait_expired(32'(cnt_q), 32'(lim));

  // R10: a zero limit never lets a wait expire
  a_r10_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (lim == '0) |-> !expired);

  // R10: the count starts again from zero after every launch
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/repair_seq_region.sv
module repair_seq_region #(
  parameter int unsigned N_INC = 7,
  localparam int unsigned RW   = $clog2(N_INC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  output logic [RW-1:0] used,
  output logic          full
);

  logic [RW-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   used_q <= '0;
    else if (commit && !full)     used_q <= used_q + 1'b1;
  end

  assign used = used_q;
  assign full = (32'(used_q) >= N_INC);

  // R9: the pointer never passes the number of incremental regions
  a_r9_never_over: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used_q) <= N_INC);

  // R8: the pointer only ever advances by one
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q != $past(used_q)) |-> (used_q == $past(used_q) + 1'b1));

  // R9: a commit is never requested on a full pointer
  a_r9_commit_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !full);

endmodule

// File: rtl/repair_seq.sv
module repair_seq #(
  parameter int unsigned N_INC = 7,
  parameter int unsigned TW    = 16,
  localparam int unsigned RW   = $clog2(N_INC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          field_mode,
  input  logic [TW-1:0] timeout_lim,
  output logic          otp_start,
  input  logic          otp_done,
  input  logic          otp_pass,
  output logic          mt_start,
  input  logic          mt_done,
  input  logic          mt_pass,
  output logic          ra_start,
  input  logic          ra_done,
  input  logic          ra_ok,
  output logic          pg_start,
  output logic [RW-1:0] pg_region,
  input  logic          pg_done,
  input  logic          pg_pass,
  output logic          busy,
  output logic [2:0]    status,
  output logic [1:0]    tmo_phase,
  output logic [RW-1:0] inc_used
);
  import repair_seq_pkg::*;

  rs_fsm_e              fsm_q, fsm_n;
  rs_status_e           status_q, status_n;
  logic [NUM_ENG-1:0]   strb_q, strb_n;
  logic [NUM_ENG-1:0]   done_v, pass_v;
  logic                 mode_q, mode_n;
  logic                 clean_q, clean_n;
  logic [1:0]           tph_q, tph_n;
  logic [RW-1:0]        region_q, region_n;
  logic [1:0]           cur_idx;
  logic                 cur_done, cur_pass;
  logic                 expired, commit, full;
  logic [RW-1:0]        used;

  assign done_v   = {pg_done, ra_done, mt_done, otp_done};
  assign pass_v   = {pg_pass, ra_ok,   mt_pass, otp_pass};
  assign cur_idx  = phase_of(fsm_q);
  assign cur_done = (fsm_q != F_IDLE) && done_v[cur_idx];
  assign cur_pass = pass_v[cur_idx];

  repair_seq_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (|strb_n),
    .run     (fsm_q != F_IDLE),
    .lim     (timeout_lim),
    .expired (expired)
  );

  repair_seq_region #(.N_INC(N_INC)) u_region (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .used   (used),
    .full   (full)
  );

  always_comb begin
    fsm_n    = fsm_q;
    status_n = status_q;
    strb_n   = '0;
    mode_n   = mode_q;
    clean_n  = clean_q;
    tph_n    = tph_q;
    region_n = region_q;
    commit   = 1'b0;
    if (fsm_q == F_IDLE) begin
      if (start) begin
        fsm_n         = F_OTP;
        strb_n[E_OTP] = 1'b1;
        status_n      = ST_BUSY;
        mode_n        = field_mode;
        clean_n       = 1'b0;
        tph_n         = '0;
      end
    end else if (cur_done) begin
      fsm_n = F_IDLE;
      case (fsm_q)
        F_OTP: begin
          if (cur_pass) begin
            fsm_n        = F_MT;
            strb_n[E_MT] = 1'b1;
            clean_n      = 1'b1;
          end else begin
            status_n = ST_FAIL_OTP;
          end
        end
        F_MT: begin
          if (cur_pass) begin
            status_n = ST_PASS;
          end else begin
            fsm_n        = F_RA;
            strb_n[E_RA] = 1'b1;
          end
        end
        F_RA: begin
          if (!cur_pass) begin
            status_n = ST_UNREP;
          end else if (mode_q && full) begin
            status_n = ST_FULL;
          end else begin
            fsm_n        = F_PG;
            strb_n[E_PG] = 1'b1;
            region_n     = RW'(next_region(32'(used), mode_q));
          end
        end
        F_PG: begin
          if (cur_pass) begin
            status_n = ST_PASS;
            commit   = mode_q;
          end else begin
            status_n = ST_PROG_FAIL;
          end
        end
        default: status_n = ST_IDLE;
      endcase
    end else if (expired) begin
      fsm_n    = F_IDLE;
      status_n = ST_TIMEOUT;
      tph_n    = cur_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q    <= F_IDLE;
      status_q <= ST_IDLE;
      strb_q   <= '0;
      mode_q   <= 1'b0;
      clean_q  <= 1'b0;
      tph_q    <= '0;
      region_q <= '0;
    end else begin
      fsm_q    <= fsm_n;
      status_q <= status_n;
      strb_q   <= strb_n;
      mode_q   <= mode_n;
      clean_q  <= clean_n;
      tph_q    <= tph_n;
      region_q <= region_n;
    end
  end

  assign otp_start = strb_q[E_OTP];
  assign mt_start  = strb_q[E_MT];
  assign ra_start  = strb_q[E_RA];
  assign pg_start  = strb_q[E_PG];
  assign pg_region = region_q;
  assign busy      = (fsm_q != F_IDLE);
  assign status    = status_q;
  assign tmo_phase = tph_q;
  assign inc_used  = used;

  // R2: at most one engine is launched in any cycle
  a_r2_one_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({otp_start, mt_start, ra_start, pg_start}));

  // R3: the SRAM test never starts without a clean OTP phase in this run
  a_r3_mt_needs_otp: assert property (@(posedge clk) disable iff (!rst_n)
    mt_start |-> clean_q);

  // R4: programming is launched only straight after analysis
  a_r4_pg_after_ra: assert property (@(posedge clk) disable iff (!rst_n)
    pg_start |-> ($past(fsm_q) == F_RA));

  // R7: factory runs always target region zero
  a_r7_factory_region0: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_start && !mode_q) |-> (pg_region == '0));

  // R8: field runs never target region zero
  a_r8_field_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_start && mode_q) |-> (pg_region != '0));

  // R10: an unanswered wait past its limit ends in the timeout status
  a_r10_timeout_named: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur_done && expired) |=> (status == 3'd6 && tmo_phase == $past(cur_idx)));

  // R12: the outcome is held while idle and no start arrives
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(status));

endmodule

// File: tb/repair_seq_bench.sv
module rs_eng_model (
  input  logic clk,
  input  logic strb,
  output logic done,
  output logic ok
);
  int  delay    = 0;
  bit  hang     = 1'b0;
  bit  pval     = 1'b1;
  int  launches = 0;
  int  cnt      = 0;
  bit  armed    = 1'b0;
  logic d_r     = 1'b0;
  logic ok_r    = 1'b0;

  assign done = d_r;
  assign ok   = ok_r;

  always @(negedge clk) begin
    d_r <= 1'b0;
    if (strb) begin
      launches = launches + 1;
      if (!hang && delay == 0) begin
        d_r   <= 1'b1;
        ok_r  <= pval;
        armed = 1'b0;
      end else begin
        cnt   = delay;
        armed = 1'b1;
      end
    end else if (armed && !hang) begin
      cnt = cnt - 1;
      if (cnt <= 0) begin
        d_r   <= 1'b1;
        ok_r  <= pval;
        armed = 1'b0;
      end
    end
  end
endmodule

module repair_seq_bench;
  localparam int N_INC = 7;
  localparam int TW    = 16;
  localparam int RW    = $clog2(N_INC + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          field_mode = 1'b0;
  logic [TW-1:0] timeout_lim = 16'd100;
  logic          otp_start, otp_done, otp_pass;
  logic          mt_start, mt_done, mt_pass;
  logic          ra_start, ra_done, ra_ok;
  logic          pg_start, pg_done, pg_pass;
  logic [RW-1:0] pg_region;
  logic          busy;
  logic [2:0]    status;
  logic [1:0]    tmo_phase;
  logic [RW-1:0] inc_used;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int last_region = -1;

  always #5 clk = ~clk;

  repair_seq #(.N_INC(N_INC), .TW(TW)) u_repair_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .field_mode(field_mode),
    .timeout_lim(timeout_lim),
    .otp_start(otp_start), .otp_done(otp_done), .otp_pass(otp_pass),
    .mt_start(mt_start), .mt_done(mt_done), .mt_pass(mt_pass),
    .ra_start(ra_start), .ra_done(ra_done), .ra_ok(ra_ok),
    .pg_start(pg_start), .pg_region(pg_region), .pg_done(pg_done), .pg_pass(pg_pass),
    .busy(busy), .status(status), .tmo_phase(tmo_phase), .inc_used(inc_used)
  );

  rs_eng_model u_otp (.clk(clk), .strb(otp_start), .done(otp_done), .ok(otp_pass));
  rs_eng_model u_mt  (.clk(clk), .strb(mt_start),  .done(mt_done),  .ok(mt_pass));
  rs_eng_model u_ra  (.clk(clk), .strb(ra_start),  .done(ra_done),  .ok(ra_ok));
  rs_eng_model u_pg  (.clk(clk), .strb(pg_start),  .done(pg_done),  .ok(pg_pass));

  always @(negedge clk) if (pg_start) last_region <= int'(pg_region);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int d, input bit op, input bit mp, input bit rp, input bit pp);
    u_otp.delay = d; u_otp.hang = 0; u_otp.pval = op; u_otp.launches = 0;
    u_mt.delay  = d; u_mt.hang  = 0; u_mt.pval  = mp; u_mt.launches  = 0;
    u_ra.delay  = d; u_ra.hang  = 0; u_ra.pval  = rp; u_ra.launches  = 0;
    u_pg.delay  = d; u_pg.hang  = 0; u_pg.pval  = pp; u_pg.launches  = 0;
    last_region = -1;
  endtask

  task automatic run(input bit fld);
    @(negedge clk);
    field_mode = fld;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    check("R2 run completes", int'(busy), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 status in reset", int'(status), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobes after reset", int'({otp_start, mt_start, ra_start, pg_start}), 0);
    check("R1 region count after reset", int'(inc_used), 0);
  endtask

  task automatic t_factory_full_path;
    setup(2, 1, 0, 1, 1);
    run(1'b0);
    check("R4 factory repair status", int'(status), 2);
    check("R4 order mt launched", u_mt.launches, 1);
    check("R4 order ra launched", u_ra.launches, 1);
    check("R4 order pg launched", u_pg.launches, 1);
    check("R7 factory region", last_region, 0);
    check("R7 count unchanged", int'(inc_used), 0);
  endtask

  task automatic t_otp_fail;
    setup(1, 0, 0, 1, 1);
    run(1'b1);
    check("R3 otp fail status", int'(status), 3);
    check("R3 no sram test", u_mt.launches, 0);
  endtask

  task automatic t_clean_sram;
    setup(0, 1, 1, 1, 1);
    run(1'b1);
    check("R5 clean sram status", int'(status), 2);
    check("R5 no analysis", u_ra.launches, 0);
    check("R5 no programming", u_pg.launches, 0);
  endtask

  task automatic t_unrepairable;
    setup(1, 1, 0, 0, 1);
    run(1'b1);
    check("R6 unrepairable status", int'(status), 4);
    check("R6 no programming", u_pg.launches, 0);
  endtask

  task automatic t_prog_fail;
    setup(1, 1, 0, 1, 0);
    run(1'b1);
    check("R11 prog fail status", int'(status), 7);
    check("R11 count unchanged", int'(inc_used), 0);
  endtask

  task automatic t_field_fill;
    for (int k = 1; k <= N_INC; k++) begin
      setup(1, 1, 0, 1, 1);
      run(1'b1);
      check("R8 field status", int'(status), 2);
      check("R8 field region", last_region, k);
      check("R8 field count", int'(inc_used), k);
    end
  endtask

  task automatic t_region_full;
    setup(1, 1, 0, 1, 1);
    run(1'b1);
    check("R9 full status", int'(status), 5);
    check("R9 no programming", u_pg.launches, 0);
    check("R9 count stays", int'(inc_used), N_INC);
    setup(1, 1, 0, 1, 1);
    run(1'b0);
    check("R9 factory ok when full", int'(status), 2);
    check("R9 factory region when full", last_region, 0);
  endtask

  task automatic t_timeout;
    timeout_lim = 16'd4;
    setup(4, 1, 0, 0, 1);
    run(1'b0);
    check("R10 done on last edge accepted", int'(status), 4);
    setup(1, 1, 0, 0, 1);
    u_mt.delay = 5;
    run(1'b0);
    check("R10 one edge late times out", int'(status), 6);
    check("R10 phase names sram test", int'(tmo_phase), 1);
    setup(1, 1, 0, 1, 1);
    u_otp.hang = 1;
    run(1'b0);
    check("R10 otp hang status", int'(status), 6);
    check("R10 phase names otp", int'(tmo_phase), 0);
    u_otp.hang = 0;
    setup(1, 1, 0, 1, 1);
    u_pg.hang = 1;
    run(1'b0);
    check("R10 phase names programmer", int'(tmo_phase), 3);
    u_pg.hang = 0;
    timeout_lim = 16'd0;
    setup(20, 1, 1, 1, 1);
    run(1'b0);
    check("R10 zero limit disables", int'(status), 2);
    timeout_lim = 16'd100;
  endtask

  task automatic t_hold_and_ignore;
    setup(8, 1, 1, 1, 1);
    @(negedge clk);
    field_mode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 busy status mid run", int'(status), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    check("R2 start while busy ignored", u_otp.launches, 1);
    check("R2 run ends normally", int'(status), 2);
    repeat (12) @(negedge clk);
    check("R12 status held", int'(status), 2);
    check("R12 busy stays low", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_factory_full_path();
    t_otp_fail();
    t_clean_sram();
    t_unrepairable();
    t_prog_fail();
    t_field_fill();
    t_region_full();
    t_timeout();
    t_hold_and_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule